// File: doc/BRIEF.md
# Iterative Bit-Manipulation Execution Unit

This block is a multi-cycle execution unit for the basic bit-manipulation operations and the shifted-add address-generation operations of a 32-bit processor. The issue logic presents an operation code, two operands and a one-cycle start strobe. Some cycles later the unit returns a result together with a one-cycle done strobe. Register-file access and instruction decoding stay outside the unit. For the immediate rotate, the issue logic places the immediate on the second operand.

Bitwise logic, minimum and maximum, sign and zero extension, byte reversal, byte-wise OR-combine and shifted-add always finish on a short fixed schedule. Count-leading-zeros, count-trailing-zeros, population count and the rotates normally step through their work one bit position per cycle, so their latency depends on the data. A build-time parameter `FAST_SHIFT` replaces the stepping datapath with single-pass parallel logic. With that parameter set, every operation has the fixed schedule.

In all timing statements below, the cycle in which `start_i` is sampled high while the unit is idle counts as cycle 1.

Top module: `bitmanip_iter_unit`

## Requirements
- R1: After reset, `done_o` is 0 and `result_o` is 0.
- R2: Operation codes 0 (andn: rs1 AND NOT rs2), 1 (orn: rs1 OR NOT rs2) and 2 (xnor: NOT(rs1 XOR rs2)) return their result with `done_o` high in cycle 3.
- R3: Operation codes 6 (signed max), 7 (unsigned max), 8 (signed min) and 9 (unsigned min) return the selected operand, with done in cycle 3.
- R4: Operation codes 10 (sign-extend the low byte), 11 (sign-extend the low half-word) and 12 (zero-extend the low half-word) act on rs1, with done in cycle 3.
- R5: Operation code 16 sets each byte of rs1 to 0xFF if any bit of that byte is set, and to 0x00 otherwise. Operation code 17 reverses the byte order of rs1. Both finish with done in cycle 3.
- R6: Operation codes 18, 19 and 20 return (rs1 << N) + rs2 for N = 1, 2 and 3, truncated to 32 bits, with done in cycle 3.
- R7: Operation code 3 counts the leading zeros of rs1 and code 4 counts its trailing zeros. An all-zero operand gives 32. Done arrives in cycle 3 + (the returned count). The done strobe never arrives in cycle 2.
- R8: Operation code 5 returns the number of set bits of rs1, with done always in cycle 35.
- R9: Operation codes 13 (rotate left), 14 (rotate right) and 15 (rotate right by immediate) rotate rs1 by the low 5 bits of rs2. Done arrives in cycle 3 + amount. An amount of 0 returns rs1 unchanged in cycle 3.
- R10: With `FAST_SHIFT` set, every operation, including codes 3, 4, 5, 13, 14 and 15, returns the same result as in R2 to R9, with done in cycle 3.
- R11: `done_o` is a single-cycle pulse.
- R12: A start strobe that arrives while the unit is busy has no effect. Busy covers every cycle from cycle 2 through the done cycle. The running operation keeps its result and its latency, and no extra done strobe follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; sampled only while idle |
| op_i | input | 5 | Operation code (see requirements) |
| rs1_i | input | 32 | First operand |
| rs2_i | input | 32 | Second operand, rotate amount or immediate |
| result_o | output | 32 | Result; valid while `done_o` is high |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
Counting the start cycle as cycle 1, fixed-schedule operations are due in cycle 3. Leading-zero and trailing-zero counts are due in cycle 3 plus the count, population count in cycle 35, and rotates in cycle 3 plus the 5-bit amount. The fast-shift build has every result due in cycle 3. The bench drives the inputs and samples the outputs on falling edges only. It counts the rising edges that pass before `done_o` is first seen, compares that count plus one with the expected cycle, and checks one cycle later that the strobe has dropped. Ignored-start cases are checked by confirming that the expected latency and result of the running operation hold, and that no done appears in the window where an accepted start would have produced one.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

    typedef enum logic [4:0] {
        OP_ANDN   = 5'd0,
        OP_ORN    = 5'd1,
        OP_XNOR   = 5'd2,
        OP_CLZ    = 5'd3,
        OP_CTZ    = 5'd4,
        OP_CPOP   = 5'd5,
        OP_MAX    = 5'd6,
        OP_MAXU   = 5'd7,
        OP_MIN    = 5'd8,
        OP_MINU   = 5'd9,
        OP_SEXTB  = 5'd10,
        OP_SEXTH  = 5'd11,
        OP_ZEXTH  = 5'd12,
        OP_ROL    = 5'd13,
        OP_ROR    = 5'd14,
        OP_RORI   = 5'd15,
        OP_ORCB   = 5'd16,
        OP_REV8   = 5'd17,
        OP_SH1ADD = 5'd18,
        OP_SH2ADD = 5'd19,
        OP_SH3ADD = 5'd20
    } bmu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PREP = 2'd1,
        ST_ITER = 2'd2,
        ST_FIN  = 2'd3
    } bmu_state_e;

    function automatic logic op_is_rotate(bmu_op_e op);
        return (op == OP_ROL) || (op == OP_ROR) || (op == OP_RORI);
    endfunction

    function automatic logic op_is_zcount(bmu_op_e op);
        return (op == OP_CLZ) || (op == OP_CTZ);
    endfunction

    function automatic logic op_is_iterative(bmu_op_e op);
        return op_is_rotate(op) || op_is_zcount(op) || (op == OP_CPOP);
    endfunction

endpackage

// File: rtl/bmu_simple_ops.sv
module bmu_simple_ops
    import bmu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  bmu_op_e          op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] y_o
);
    localparam int NBYTES = WIDTH / 8;

    logic [WIDTH-1:0] orc_w;
    logic [WIDTH-1:0] rev_w;

    // byte-wise structures repeat once per byte lane
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign orc_w[8*g +: 8] = {8{|a_i[8*g +: 8]}};
        assign rev_w[8*g +: 8] = a_i[8*(NBYTES-1-g) +: 8];
    end

    always_comb begin
        case (op_i)
            OP_ANDN:   y_o = a_i & ~b_i;
            OP_ORN:    y_o = a_i | ~b_i;
            OP_XNOR:   y_o = ~(a_i ^ b_i);
            OP_MAX:    y_o = ($signed(a_i) > $signed(b_i)) ? a_i : b_i;
            OP_MAXU:   y_o = (a_i > b_i) ? a_i : b_i;
            OP_MIN:    y_o = ($signed(a_i) < $signed(b_i)) ? a_i : b_i;
            OP_MINU:   y_o = (a_i < b_i) ? a_i : b_i;
            OP_SEXTB:  y_o = {{(WIDTH-8){a_i[7]}}, a_i[7:0]};
            OP_SEXTH:  y_o = {{(WIDTH-16){a_i[15]}}, a_i[15:0]};
            OP_ZEXTH:  y_o = {{(WIDTH-16){1'b0}}, a_i[15:0]};
            OP_ORCB:   y_o = orc_w;
            OP_REV8:   y_o = rev_w;
            OP_SH1ADD: y_o = (a_i << 1) + b_i;
            OP_SH2ADD: y_o = (a_i << 2) + b_i;
            OP_SH3ADD: y_o = (a_i << 3) + b_i;
            default:   y_o = '0;
        endcase
    end

endmodule

// File: rtl/bmu_shift_step.sv
module bmu_shift_step
    import bmu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int CNT_W = 6
) (
    input  bmu_op_e          op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] acc_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [WIDTH-1:0] a_o,
    output logic [WIDTH-1:0] acc_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o
);
    // one bit position of work per call
    always_comb begin
        a_o    = a_i;
        acc_o  = acc_i;
        cnt_o  = cnt_i;
        last_o = 1'b1;
        case (op_i)
            OP_CLZ, OP_CTZ: begin
                a_o    = a_i << 1;
                acc_o  = acc_i + WIDTH'(1);
                last_o = a_o[WIDTH-1] | (acc_o == WIDTH'(WIDTH));
            end
            OP_CPOP: begin
                a_o    = a_i << 1;
                acc_o  = acc_i + WIDTH'(a_i[WIDTH-1]);
                cnt_o  = cnt_i + CNT_W'(1);
                last_o = (cnt_o == CNT_W'(WIDTH));
            end
            OP_ROL: begin
                a_o    = {a_i[WIDTH-2:0], a_i[WIDTH-1]};
                acc_o  = a_o;
                cnt_o  = cnt_i - CNT_W'(1);
                last_o = (cnt_o == '0);
            end
            OP_ROR, OP_RORI: begin
                a_o    = {a_i[0], a_i[WIDTH-1:1]};
                acc_o  = a_o;
                cnt_o  = cnt_i - CNT_W'(1);
                last_o = (cnt_o == '0);
            end
            default: begin
                last_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/bmu_shift_par.sv
module bmu_shift_par
    import bmu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int SH_W  = 5
) (
    input  bmu_op_e          op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [SH_W-1:0]  amt_i,
    output logic [WIDTH-1:0] y_o
);
    logic [WIDTH-1:0] lz_w;
    logic [WIDTH-1:0] pop_w;
    logic [WIDTH-1:0] rol_w;
    logic [WIDTH-1:0] ror_w;
    logic             hit;

    // priority scan from the top bit; trailing zeros arrive pre-reversed
    always_comb begin
        hit  = 1'b0;
        lz_w = WIDTH'(WIDTH);
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (!hit && a_i[i]) begin
                lz_w = WIDTH'(WIDTH - 1 - i);
                hit  = 1'b1;
            end
        end
    end

    always_comb begin
        pop_w = '0;
        for (int i = 0; i < WIDTH; i++) begin
            pop_w = pop_w + WIDTH'(a_i[i]);
        end
    end

    // one multiplexer per result bit
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            rol_w[i] = a_i[(i - int'(amt_i) + WIDTH) % WIDTH];
            ror_w[i] = a_i[(i + int'(amt_i)) % WIDTH];
        end
    end

    always_comb begin
        case (op_i)
            OP_CLZ, OP_CTZ:  y_o = lz_w;
            OP_CPOP:         y_o = pop_w;
            OP_ROL:          y_o = rol_w;
            OP_ROR, OP_RORI: y_o = ror_w;
            default:         y_o = '0;
        endcase
    end

endmodule

// File: rtl/bitmanip_iter_unit.sv
module bitmanip_iter_unit
    import bmu_pkg::*;
#(
    parameter int WIDTH      = 32,
    parameter bit FAST_SHIFT = 1'b0
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        start_i,
    input  logic [4:0]  op_i,
    input  logic [31:0] rs1_i,
    input  logic [31:0] rs2_i,
    output logic [31:0] result_o,
    output logic        done_o
);
    localparam int SH_W  = $clog2(WIDTH);
    localparam int CNT_W = SH_W + 1;

    typedef struct packed {
        bmu_state_e       st;
        bmu_op_e          op;
        logic [WIDTH-1:0] opa;
        logic [WIDTH-1:0] opb;
        logic [CNT_W-1:0] cnt;
        logic [WIDTH-1:0] res;
    } core_t;

    core_t cur_q, nxt_d;

    bmu_op_e          op_in;
    logic [WIDTH-1:0] rs1_rev;
    logic [WIDTH-1:0] simple_y;
    logic [WIDTH-1:0] par_y;
    logic [WIDTH-1:0] step_a, step_acc;
    logic [CNT_W-1:0] step_cnt;
    logic             step_last;

    assign op_in = bmu_op_e'(op_i);

    // trailing-zero count reuses the leading-zero path on a mirrored operand
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            rs1_rev[i] = rs1_i[WIDTH-1-i];
        end
    end

    bmu_simple_ops #(.WIDTH(WIDTH)) u_simple (
        .op_i (cur_q.op),
        .a_i  (cur_q.opa),
        .b_i  (cur_q.opb),
        .y_o  (simple_y)
    );

    bmu_shift_step #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_step (
        .op_i   (cur_q.op),
        .a_i    (cur_q.opa),
        .acc_i  (cur_q.res),
        .cnt_i  (cur_q.cnt),
        .a_o    (step_a),
        .acc_o  (step_acc),
        .cnt_o  (step_cnt),
        .last_o (step_last)
    );

    if (FAST_SHIFT) begin : g_fast
        bmu_shift_par #(.WIDTH(WIDTH), .SH_W(SH_W)) u_par (
            .op_i  (cur_q.op),
            .a_i   (cur_q.opa),
            .amt_i (cur_q.cnt[SH_W-1:0]),
            .y_o   (par_y)
        );
    end else begin : g_slow
        assign par_y = '0;
    end

    always_comb begin
        nxt_d = cur_q;
        case (cur_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    nxt_d.st  = ST_PREP;
                    nxt_d.op  = op_in;
                    nxt_d.opa = (op_in == OP_CTZ) ? rs1_rev : rs1_i;
                    nxt_d.opb = rs2_i;
                    nxt_d.cnt = op_is_rotate(op_in) ? CNT_W'(rs2_i[SH_W-1:0]) : '0;
                    nxt_d.res = '0;
                end
            end
            ST_PREP: begin
                if (!op_is_iterative(cur_q.op)) begin
                    nxt_d.res = simple_y;
                    nxt_d.st  = ST_FIN;
                end else if (FAST_SHIFT) begin
                    nxt_d.res = par_y;
                    nxt_d.st  = ST_FIN;
                end else if (op_is_rotate(cur_q.op) && (cur_q.cnt == '0)) begin
                    nxt_d.res = cur_q.opa;
                    nxt_d.st  = ST_FIN;
                end else if (op_is_zcount(cur_q.op) && cur_q.opa[WIDTH-1]) begin
                    nxt_d.res = '0;
                    nxt_d.st  = ST_FIN;
                end else begin
                    nxt_d.st = ST_ITER;
                end
            end
            ST_ITER: begin
                nxt_d.opa = step_a;
                nxt_d.cnt = step_cnt;
                nxt_d.res = step_acc;
                if (step_last) begin
                    nxt_d.st = ST_FIN;
                end
            end
            ST_FIN: begin
                nxt_d.st = ST_IDLE;
            end
            default: begin
                nxt_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign done_o   = (cur_q.st == ST_FIN);
    assign result_o = cur_q.res;

endmodule

// File: rtl/bitmanip_iter_unit_chk.sv
module bitmanip_iter_unit_chk
    import bmu_pkg::*;
#(
    parameter int WIDTH      = 32,
    parameter bit FAST_SHIFT = 1'b0
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        start_i,
    input logic [4:0]  op_i,
    input logic [31:0] result_o,
    input logic        done_o,
    input logic        busy_i,
    input logic [4:0]  op_q_i
);
    logic accept;
    logic fixed_op;
    logic count_op;

    assign accept   = start_i && !busy_i;
    assign fixed_op = !op_is_iterative(bmu_op_e'(op_i));
    assign count_op = op_is_zcount(bmu_op_e'(op_q_i)) || (bmu_op_e'(op_q_i) == OP_CPOP);

    // R11
    p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R2 (fixed-schedule operations)
    p_fixed_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept && fixed_op) |=> ##1 done_o);

    // R7
    p_no_early_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept |=> !done_o);

    // R7, R8
    p_count_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && count_op) |-> (result_o <= 32'(WIDTH)));

    // R12
    p_busy_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && busy_i) |=> $stable(op_q_i));

    if (FAST_SHIFT) begin : g_fast_chk
        // R10
        p_fast_all_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            accept |=> ##1 done_o);
    end

endmodule

bind bitmanip_iter_unit bitmanip_iter_unit_chk #(
    .WIDTH      (WIDTH),
    .FAST_SHIFT (FAST_SHIFT)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .op_i     (op_i),
    .result_o (result_o),
    .done_o   (done_o),
    .busy_i   (cur_q.st != ST_IDLE),
    .op_q_i   (cur_q.op)
);

// File: tb/bitmanip_iter_unit_bench.sv
`timescale 1ns/1ps
module bitmanip_iter_unit_bench;

    typedef struct packed {
        logic [4:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp;
        logic [7:0]  lat;
    } vec_t;

    localparam int NVEC = 29;
    localparam vec_t VECS [NVEC] = '{
        '{5'd0,  32'hF0F0_FFFF, 32'h0FF0_00FF, 32'hF000_FF00, 8'd3},
        '{5'd1,  32'h0000_1234, 32'hFFFF_0000, 32'h0000_FFFF, 8'd3},
        '{5'd2,  32'hAAAA_5555, 32'hA5A5_A5A5, 32'hF0F0_0F0F, 8'd3},
        '{5'd6,  32'hFFFF_FFFF, 32'h0000_0005, 32'h0000_0005, 8'd3},
        '{5'd7,  32'hFFFF_FFFF, 32'h0000_0005, 32'hFFFF_FFFF, 8'd3},
        '{5'd8,  32'h8000_0000, 32'h7FFF_FFFF, 32'h8000_0000, 8'd3},
        '{5'd9,  32'h8000_0000, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 8'd3},
        '{5'd10, 32'h0000_1280, 32'h0000_0000, 32'hFFFF_FF80, 8'd3},
        '{5'd11, 32'h1234_8001, 32'h0000_0000, 32'hFFFF_8001, 8'd3},
        '{5'd12, 32'hABCD_1234, 32'h0000_0000, 32'h0000_1234, 8'd3},
        '{5'd16, 32'h0100_8000, 32'h0000_0000, 32'hFF00_FF00, 8'd3},
        '{5'd17, 32'h1122_3344, 32'h0000_0000, 32'h4433_2211, 8'd3},
        '{5'd18, 32'h0000_0010, 32'h0000_0001, 32'h0000_0021, 8'd3},
        '{5'd19, 32'h4000_0001, 32'h0000_0003, 32'h0000_0007, 8'd3},
        '{5'd20, 32'h0000_0002, 32'hFFFF_FFF0, 32'h0000_0000, 8'd3},
        '{5'd3,  32'h0001_0000, 32'h0000_0000, 32'h0000_000F, 8'd18},
        '{5'd3,  32'h8000_0000, 32'h0000_0000, 32'h0000_0000, 8'd3},
        '{5'd3,  32'h0000_0000, 32'h0000_0000, 32'h0000_0020, 8'd35},
        '{5'd4,  32'h0000_0100, 32'h0000_0000, 32'h0000_0008, 8'd11},
        '{5'd4,  32'h0000_0000, 32'h0000_0000, 32'h0000_0020, 8'd35},
        '{5'd4,  32'h0000_0001, 32'h0000_0000, 32'h0000_0000, 8'd3},
        '{5'd5,  32'hF0F0_0001, 32'h0000_0000, 32'h0000_0009, 8'd35},
        '{5'd5,  32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 8'd35},
        '{5'd13, 32'h8000_0001, 32'h0000_0001, 32'h0000_0003, 8'd4},
        '{5'd14, 32'h0000_00F1, 32'h0000_0004, 32'h1000_000F, 8'd7},
        '{5'd15, 32'h1234_5678, 32'h0000_0028, 32'h7812_3456, 8'd11},
        '{5'd13, 32'hDEAD_BEEF, 32'h0000_0020, 32'hDEAD_BEEF, 8'd3},
        '{5'd14, 32'h0000_0001, 32'h0000_001F, 32'h0000_0002, 8'd34},
        '{5'd13, 32'h1234_5678, 32'h0000_0004, 32'h2345_6781, 8'd7}
    };

    logic        clk;
    logic        rst_n;
    logic        start;
    logic [4:0]  op;
    logic [31:0] rs1, rs2;
    logic [31:0] res_s, res_f;
    logic        done_s, done_f;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    bitmanip_iter_unit u_bitmanip_iter_unit (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
        .rs1_i(rs1), .rs2_i(rs2), .result_o(res_s), .done_o(done_s)
    );

    bitmanip_iter_unit #(.FAST_SHIFT(1'b1)) u_bitmanip_iter_unit_fast (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
        .rs1_i(rs1), .rs2_i(rs2), .result_o(res_f), .done_o(done_f)
    );

    function automatic string tag_of(logic [4:0] code);
        case (code)
            5'd0, 5'd1, 5'd2:               return "R2";
            5'd6, 5'd7, 5'd8, 5'd9:         return "R3";
            5'd10, 5'd11, 5'd12:            return "R4";
            5'd16, 5'd17:                   return "R5";
            5'd18, 5'd19, 5'd20:            return "R6";
            5'd3, 5'd4:                     return "R7";
            5'd5:                           return "R8";
            default:                        return "R9";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
        end
    endtask

    // issue one operation; counts rising edges until done is seen
    task automatic run_op(input logic [4:0] c, input logic [31:0] a, input logic [31:0] b,
                          output int lat_s, output logic [31:0] r_s,
                          output int lat_f, output logic [31:0] r_f,
                          output bit pulse_ok);
        int edges;
        @(negedge clk);
        op = c; rs1 = a; rs2 = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        edges = 1;
        lat_f = 0;
        r_f   = '0;
        while (edges < 100) begin
            if (done_f && lat_f == 0) begin
                lat_f = edges + 1;
                r_f   = res_f;
            end
            if (done_s) break;
            @(negedge clk);
            edges++;
        end
        lat_s = edges + 1;
        r_s   = res_s;
        @(negedge clk);
        pulse_ok = !done_s;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int          ls, lf, edges;
        logic [31:0] rsv, rfv;
        bit          pok, seen;

        rst_n = 1'b0; start = 1'b0; op = '0; rs1 = '0; rs2 = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(done_s == 1'b0, "R1", "done after reset", 32'(done_s), 32'd0);
        check(res_s == 32'd0, "R1", "result after reset", res_s, 32'd0);
        check(done_f == 1'b0 && res_f == 32'd0, "R1", "fast build reset", res_f, 32'd0);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            run_op(VECS[i].op, VECS[i].a, VECS[i].b, ls, rsv, lf, rfv, pok);
            check(rsv == VECS[i].exp, tag_of(VECS[i].op), $sformatf("vec %0d result", i),
                  rsv, VECS[i].exp);
            check(ls == int'(VECS[i].lat), tag_of(VECS[i].op), $sformatf("vec %0d latency", i),
                  32'(ls), 32'(VECS[i].lat));
            check(pok, "R11", $sformatf("vec %0d done pulse width", i), 32'(!pok), 32'd0);
            check(rfv == VECS[i].exp, "R10", $sformatf("vec %0d fast result", i),
                  rfv, VECS[i].exp);
            check(lf == 3, "R10", $sformatf("vec %0d fast latency", i), 32'(lf), 32'd3);
        end

        // R12: start during iteration is ignored
        @(negedge clk);
        op = 5'd5; rs1 = 32'hFFFF_FFFF; rs2 = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        edges = 1;
        repeat (3) begin @(negedge clk); edges++; end
        op = 5'd0; rs1 = '0; rs2 = '0; start = 1'b1;
        @(negedge clk);
        edges++;
        start = 1'b0;
        while (edges < 100 && !done_s) begin @(negedge clk); edges++; end
        check(edges + 1 == 35, "R12", "busy start latency", 32'(edges + 1), 32'd35);
        check(res_s == 32'd32, "R12", "busy start result", res_s, 32'd32);
        // R12: start in the done cycle is ignored too
        op = 5'd0; rs1 = 32'h1; rs2 = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 1'b0;
        repeat (5) begin
            if (done_s) seen = 1'b1;
            @(negedge clk);
        end
        check(!seen, "R12", "no done after ignored start", 32'(seen), 32'd0);
        check(res_s == 32'd32, "R12", "result held after ignored start", res_s, 32'd32);

        // unit still accepts work afterwards
        run_op(5'd3, 32'h0000_0001, 32'h0, ls, rsv, lf, rfv, pok);
        check(rsv == 32'd31 && ls == 34, "R7", "clz after ignored start", rsv, 32'd31);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule